// File: doc/BRIEF.md
# Parity-Protected Write-Through Data Cache

This block is a direct-mapped data cache that sits between a processor port and a single-word memory port. Stores always go through to memory. A store that finds its line resident also updates the cached word. A store that misses leaves the cache untouched, so no line is ever allocated on a write. A load that misses brings in the whole line, one word at a time starting at word 0, and then returns the requested word.

Every stored word carries an even-parity bit. It is generated whenever the word is written, either from a fill or from a store hit, and it is checked on every load hit. Memory always holds the current copy of every word, so a word whose parity fails can be recovered without loss. The load is treated as a miss, the line is fetched again, and the correct data is returned. Each such recovery advances an error counter.

A test hook flips one chosen bit of one stored word, so the recovery path can be exercised on purpose.

Top module: `wt_parity_cache`

## Requirements
- R1: After reset, cpu_ready is 1, mem_req is 0 and err_count is 0, and every line is invalid, so the first load to any address misses.
- R2: A load that hits with good parity raises cpu_done for one cycle, one clock after the request is accepted, with the word on cpu_rdata and no memory access.
- R3: A load that misses reads the 4 words of its line (word offset = address bits [1:0], line index = bits [5:2], tag = the bits above) from memory in the order offset 0, 1, 2, 3. It writes them into the cache, marks the line valid and returns the requested word with cpu_done.
- R4: A store that hits performs exactly one memory write of its address and data, and updates the cached word, so a later load hits and returns the new data.
- R5: A store that misses performs exactly one memory write and does not allocate, so a later load of that address misses.
- R6: Parity is even over the 32 data bits plus the stored parity bit. A load hit whose stored word fails the check is handled as a miss: the line is refetched and the correct memory data is returned.
- R7: err_count increases by exactly one for each load recovered from a parity failure, and is unchanged by clean accesses.
- R8: cpu_ready is 0 from the acceptance of a request until its cpu_done. While mem_req waits for mem_ack, it holds its address and direction.
- R9: When idle, with cpu_req low, an inj_req inverts bit inj_bit (0 to 31 are data bits, 32 is the parity bit) of word inj_word of line inj_line. It keeps cpu_ready low for one cycle and changes no other word.
- R10: A store hit rewrites the word with fresh parity, so a word corrupted by injection then reads back as a clean hit.
- R11: A load miss to a line that holds another tag replaces that line, so the address previously held there misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, accepted when cpu_ready is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_done |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory direction, 1 = write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the current memory word |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| inj_req | input | 1 | Error injection request |
| inj_line | input | log2(LINES) | Line to corrupt |
| inj_word | input | log2(WORDS) | Word within that line |
| inj_bit | input | log2(DATA_W+1) | Bit to invert, DATA_W selects the parity bit |
| err_count | output | ERR_W | Count of recovered parity failures |

## Verification
The bench keeps the default geometry of 16 lines of 4 words and 32-bit data, but shrinks ADDR_W to 10. That leaves a 4-bit tag over a 1024-word memory, so random addresses often alias into the same line: hits, conflict misses and store misses all occur often in a few hundred operations. Because the tag is small, a bench-side shadow of the valid bits, tags and corrupted-word flags can predict every hit, refetch and counter step. Directed cases add three checks: injection into a data bit and into the parity bit, a store hit over a corrupted word, and a clean hit on a neighbour of a corrupted word.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL,
    ST_WMEM,
    ST_INJ
  } wtc_state_e;
endpackage

// File: rtl/wtc_ram.sv
module wtc_ram #(
  parameter int WIDTH = 33,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/wt_parity_cache.sv
module wt_parity_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int ERR_W  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int BIT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              inj_req,
  input  logic [IDX_W-1:0]  inj_line,
  input  logic [OFF_W-1:0]  inj_word,
  input  logic [BIT_W-1:0]  inj_bit,
  output logic [ERR_W-1:0]  err_count
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int ENT_W  = DATA_W + 1;
  localparam int RAM_D  = LINES * WORDS;
  localparam int RAM_AW = IDX_W + OFF_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  wtc_state_e state;
  logic              rq_we;
  logic [TAG_W-1:0]  rq_tag;
  logic [IDX_W-1:0]  rq_idx;
  logic [OFF_W-1:0]  rq_off;
  logic [DATA_W-1:0] rq_wdata;
  logic [OFF_W-1:0]  fill_cnt;
  logic [RAM_AW-1:0] inj_addr_q;
  logic [BIT_W-1:0]  inj_bit_q;

  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [ENT_W-1:0]  ram_wdata, ram_rdata;
  logic              tag_valid, tag_we;
  logic [TAG_W-1:0]  tag_rd;
  logic              hit, par_bad, fill_last;

  wtc_ram #(.WIDTH(ENT_W), .DEPTH(RAM_D)) u_data (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  wtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .wr_en(tag_we), .wr_idx(rq_idx), .wr_tag(rq_tag),
    .rd_idx(rq_idx), .rd_valid(tag_valid), .rd_tag(tag_rd)
  );

  assign hit       = tag_valid && (tag_rd == rq_tag);
  assign par_bad   = ^ram_rdata;
  assign fill_last = (fill_cnt == LAST_OFF);
  assign tag_we    = (state == ST_FILL) && mem_ack && fill_last;
  assign ram_raddr = cpu_req ? cpu_addr[RAM_AW-1:0] : {inj_line, inj_word};

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {rq_idx, rq_off};
    ram_wdata = {^rq_wdata, rq_wdata};
    case (state)
      ST_LOOKUP: ram_we = rq_we && hit;
      ST_FILL: begin
        ram_we    = mem_ack;
        ram_waddr = {rq_idx, fill_cnt};
        ram_wdata = {^mem_rdata, mem_rdata};
      end
      ST_INJ: begin
        ram_we    = 1'b1;
        ram_waddr = inj_addr_q;
        ram_wdata = ram_rdata ^ (ENT_W'(1) << inj_bit_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cpu_ready  <= 1'b1;
      cpu_done   <= 1'b0;
      cpu_rdata  <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      err_count  <= '0;
      rq_we      <= 1'b0;
      rq_tag     <= '0;
      rq_idx     <= '0;
      rq_off     <= '0;
      rq_wdata   <= '0;
      fill_cnt   <= '0;
      inj_addr_q <= '0;
      inj_bit_q  <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            rq_we     <= cpu_we;
            rq_tag    <= cpu_addr[ADDR_W-1 -: TAG_W];
            rq_idx    <= cpu_addr[RAM_AW-1 -: IDX_W];
            rq_off    <= cpu_addr[OFF_W-1:0];
            rq_wdata  <= cpu_wdata;
            cpu_ready <= 1'b0;
            state     <= ST_LOOKUP;
          end else if (inj_req) begin
            inj_addr_q <= {inj_line, inj_word};
            inj_bit_q  <= inj_bit;
            cpu_ready  <= 1'b0;
            state      <= ST_INJ;
          end
        end
        ST_LOOKUP: begin
          if (rq_we) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {rq_tag, rq_idx, rq_off};
            mem_wdata <= rq_wdata;
            state     <= ST_WMEM;
          end else if (hit && !par_bad) begin
            cpu_rdata <= ram_rdata[DATA_W-1:0];
            cpu_done  <= 1'b1;
            cpu_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            if (hit) err_count <= err_count + 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {rq_tag, rq_idx, {OFF_W{1'b0}}};
            fill_cnt <= '0;
            state    <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            if (fill_cnt == rq_off) cpu_rdata <= mem_rdata;
            if (fill_last) begin
              mem_req   <= 1'b0;
              cpu_done  <= 1'b1;
              cpu_ready <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              fill_cnt <= fill_cnt + 1'b1;
              mem_addr <= mem_addr + 1'b1;
            end
          end
        end
        ST_WMEM: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            cpu_done  <= 1'b1;
            cpu_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_INJ: begin
          cpu_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_stall_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_fill_base_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && !mem_we) |-> (mem_addr[OFF_W-1:0] == '0));

  assert_fill_order_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ack && (mem_addr[OFF_W-1:0] != LAST_OFF))
      |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_err_step_R7: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) |-> (err_count == $past(err_count) + 1'b1));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  assert_no_write_alloc_R5: assert property (@(posedge clk) disable iff (rst)
    tag_we |-> (mem_req && !mem_we));
endmodule

// File: tb/wt_parity_cache_tb.sv
module wt_parity_cache_tb;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int MEMW   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_ready, cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic              mem_req, mem_we, mem_ack;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              inj_req = 0;
  logic [3:0]        inj_line = '0;
  logic [1:0]        inj_word = '0;
  logic [5:0]        inj_bit = '0;
  logic [7:0]        err_count;

  wt_parity_cache #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .inj_req(inj_req), .inj_line(inj_line), .inj_word(inj_word), .inj_bit(inj_bit),
    .err_count(err_count)
  );

  // memory model
  logic [DATA_W-1:0] mem_arr [MEMW];
  logic [ADDR_W-1:0] rd_log [4];
  int rd_cnt = 0, wr_cnt = 0, wait_cnt = 0;
  logic ack_q = 1'b0;
  logic [DATA_W-1:0] rdata_q = '0;
  assign mem_ack   = ack_q;
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      wait_cnt <= 0;
    end else if (ack_q) begin
      ack_q <= 1'b0;
      wait_cnt <= int'($urandom_range(0, 3));
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        ack_q <= 1'b1;
        if (mem_we) begin
          mem_arr[mem_addr] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rdata_q <= mem_arr[mem_addr];
          rd_log[rd_cnt % 4] <= mem_addr;
          rd_cnt <= rd_cnt + 1;
        end
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  // shadow of the cache state
  logic        s_valid [16];
  logic [3:0]  s_tag   [16];
  logic        s_bad   [64];

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit pred_hit(input logic [ADDR_W-1:0] a);
    return s_valid[a[5:2]] && (s_tag[a[5:2]] == a[9:6]);
  endfunction

  task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
    bit h, bad, fill;
    int rd0, wr0, cyc;
    logic [7:0] e0;
    h = pred_hit(a);
    bad = s_bad[a[5:0]];
    fill = !h || bad;
    rd0 = rd_cnt; wr0 = wr_cnt; e0 = err_count;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 0;
    cyc = 0;
    while (!cpu_done) begin
      chk(cpu_ready == 0, "R8", "ready while busy", cpu_ready, 0);
      @(negedge clk);
      cyc++;
    end
    chk(cpu_rdata == mem_arr[a], req, "load data", cpu_rdata, mem_arr[a]);
    chk((rd_cnt - rd0) == (fill ? 4 : 0), req, "memory reads", rd_cnt - rd0, fill ? 4 : 0);
    chk(wr_cnt == wr0, req, "no memory write on load", wr_cnt - wr0, 0);
    chk(err_count == e0 + 8'(h && bad), "R7", "error count", err_count, e0 + 8'(h && bad));
    if (!fill) chk(cyc == 1, "R2", "hit latency", cyc, 1);
    if (fill) begin
      for (int k = 0; k < 4; k++)
        chk(rd_log[(rd0 + k) % 4] == {a[9:2], 2'(k)}, "R3", "fill order",
            rd_log[(rd0 + k) % 4], {a[9:2], 2'(k)});
      s_valid[a[5:2]] = 1;
      s_tag[a[5:2]] = a[9:6];
      for (int k = 0; k < 4; k++) s_bad[{a[5:2], 2'(k)}] = 0;
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input string req);
    bit h;
    int rd0, wr0;
    logic [7:0] e0;
    h = pred_hit(a);
    rd0 = rd_cnt; wr0 = wr_cnt; e0 = err_count;
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0;
    while (!cpu_done) begin
      chk(cpu_ready == 0, "R8", "ready while busy", cpu_ready, 0);
      @(negedge clk);
    end
    chk(wr_cnt - wr0 == 1, req, "one memory write", wr_cnt - wr0, 1);
    chk(mem_arr[a] == d, req, "memory data", mem_arr[a], d);
    chk(rd_cnt == rd0, req, "no memory read on store", rd_cnt - rd0, 0);
    chk(err_count == e0, "R7", "count unchanged on store", err_count, e0);
    if (h) s_bad[a[5:0]] = 0;
  endtask

  task automatic do_inject(input logic [3:0] ln, input logic [1:0] wd, input logic [5:0] b);
    int rd0, wr0, cyc;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    inj_req = 1; inj_line = ln; inj_word = wd; inj_bit = b;
    @(negedge clk);
    inj_req = 0;
    cyc = 0;
    while (!cpu_ready) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 1, "R9", "inject busy cycles", cyc, 1);
    chk(rd_cnt == rd0 && wr_cnt == wr0, "R9", "no memory traffic", rd_cnt - rd0, 0);
    s_bad[{ln, wd}] = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < MEMW; i++) mem_arr[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    for (int i = 0; i < 16; i++) begin s_valid[i] = 0; s_tag[i] = '0; end
    for (int i = 0; i < 64; i++) s_bad[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cpu_ready == 1, "R1", "ready after reset", cpu_ready, 1);
    chk(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);
    chk(err_count == 0, "R1", "err_count after reset", err_count, 0);

    do_read(10'h010, "R1");      // first access misses
    do_read(10'h010, "R2");
    do_read(10'h013, "R2");
    do_write(10'h011, 32'hCAFE0011, "R4");
    do_read(10'h011, "R4");
    do_write(10'h200, 32'h0BAD0200, "R5");
    do_read(10'h200, "R5");      // must miss: store did not allocate
    do_inject(4'h4, 2'd1, 6'd5);
    do_read(10'h012, "R9");      // neighbour word stays a clean hit
    do_read(10'h011, "R6");      // corrupted word recovered
    do_read(10'h011, "R6");
    do_inject(4'h4, 2'd2, 6'd32);
    do_write(10'h012, 32'h12345678, "R10");
    do_read(10'h012, "R10");
    do_inject(4'h4, 2'd3, 6'd31);
    do_read(10'h013, "R6");
    do_read(10'h050, "R11");     // conflict replaces line 4
    do_read(10'h010, "R11");     // old tag now misses

    for (int n = 0; n < 400; n++) begin
      int op;
      logic [ADDR_W-1:0] a;
      op = int'($urandom_range(0, 9));
      a = ADDR_W'($urandom_range(0, 255));
      if (op < 5) do_read(a, "R3");
      else if (op < 8) do_write(a, $urandom, "R4");
      else if (!s_bad[a[5:0]]) do_inject(a[5:2], a[1:0], 6'($urandom_range(0, 32)));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule